// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block is a serial master that pushes 21-bit configuration words into an external synthesizer-style device. The device exposes a serial data pin, a serial clock pin and a latch strobe. A host offers a word through a valid/ready handshake. The loader then clocks the word out on the data pin, most significant bit first, one bit per serial clock pulse. Once all bits are out, it raises the latch strobe, and the device copies the word into the register that the two least significant bits select.

Every pin interval is a whole number of system-clock cycles. Each interval comes from a minimum time in picoseconds, rounded up against the system clock period. The loader keeps data setup and hold, clock high and low time, the clock-to-strobe gap and the strobe width at or above their minimums. A one-cycle done pulse marks the falling strobe, so the host can chain several register writes.

Top module: `three_wire_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ser_clk, ser_strobe and ser_data are 0, wr_ready is 1 and done is 0.
- R2: A word is taken only on a cycle where wr_valid and wr_ready are both 1. wr_ready is 0 from the next cycle until the done cycle, and it is 1 again in the cycle after done. With wr_valid held at 0, no serial activity ever starts.
- R3: Each transfer makes exactly 21 rising edges on ser_clk. The ser_data values sampled at those edges, in order, are bits 20 down to 0 of the accepted word. The last two sampled bits are therefore bits 1 and 0, the register-select field.
- R4: ser_data never changes while ser_clk is 1, nor in the cycle where ser_clk rises. It changes only while ser_clk is 0.
- R5: Each ser_clk high phase lasts HIGH_CYC cycles, and each low phase between two pulses of one word lasts LOW_CYC cycles. At the default parameters both are 3 cycles.
- R6: ser_strobe rises GAP_CYC cycles after the last ser_clk falling edge, with ser_clk low all the while. At the default parameters this is 1 cycle.
- R7: ser_strobe goes high exactly once per word, for STROBE_CYC cycles. At the default parameters this is 2 cycles.
- R8: done is a single-cycle pulse in the cycle where ser_strobe has just fallen.
- R9: A synchronous reset in the middle of a transfer returns all pins to idle on the next cycle and produces no strobe and no done pulse.
- R10: While a transfer is in progress, wr_valid and wr_word have no effect. The word that was accepted is the one sent, and no second transfer follows.
- R11: Each interval is the ceiling of its minimum time divided by CLK_PERIOD_PS, with a floor of 1. LOW_CYC is the larger of the low-time and setup counts, and HIGH_CYC is the larger of the high-time and hold counts. At the defaults (10 ns clock), the span from the accept edge to the done cycle is 21*(3+3)+1+2 = 129 cycles after the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Host offers a word |
| wr_word | input | WORD_W | Word to send; bits 1:0 select the register |
| wr_ready | output | 1 | Loader idle and able to take a word |
| done | output | 1 | One-cycle pulse as the strobe falls |
| ser_data | output | 1 | Serial data pin |
| ser_clk | output | 1 | Serial clock pin, idles low |
| ser_strobe | output | 1 | Latch strobe pin, idles low |

## Verification
A wrong phase or timer value shows up at the pins within one bit period as a clock phase of the wrong length. It can also show up as a data change while the clock is high, or as a strobe that rises with the wrong gap. A wrong shift or bit count only becomes visible when the strobe rises: the sampled word differs from the one offered, or the pulse count is not 21. A handshake fault appears in the cycle after acceptance or after done, as wr_ready taking the wrong value.

// File: rtl/tlw_pkg.sv
// Shared types and helpers for the three-wire loader.
// Phase encoding is one-hot so that each pin is a direct flop output.
package tlw_pkg;

    localparam int IX_IDLE   = 0;
    localparam int IX_LOW    = 1;
    localparam int IX_HIGH   = 2;
    localparam int IX_GAP    = 3;
    localparam int IX_STROBE = 4;
    localparam int IX_DONE   = 5;

    typedef enum logic [5:0] {
        PH_IDLE   = 6'b000001,
        PH_LOW    = 6'b000010,
        PH_HIGH   = 6'b000100,
        PH_GAP    = 6'b001000,
        PH_STROBE = 6'b010000,
        PH_DONE   = 6'b100000
    } phase_t;

    // Cycles needed to cover min_ps at period_ps, never below one.
    function automatic int cycles_for(input int min_ps, input int period_ps);
        int n;
        n = (min_ps + period_ps - 1) / period_ps;
        return (n < 1) ? 1 : n;
    endfunction

    // Larger of two integers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tlw_interval_timer.sv
// Down-counter that times one phase.
// Assumes: load carries N-1 for an N-cycle phase; expired is high in the last cycle.
module tlw_interval_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Load a new interval, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/tlw_word_shifter.sv
// Holds the outgoing word and presents its top bit on the data pin.
// It also tracks how many bits have been sent.
// Assumes: load and advance are never high together; advance moves to the next bit.
module tlw_word_shifter #(
    parameter int WORD_W = 21,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              advance,
    output logic              msb,
    output logic              last
);

    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sreg;
    logic [WORD_W-1:0] shifted;
    logic [BIT_W-1:0]  bitcnt;

    // Build the shifted value stage by stage; zero enters at the tail.
    for (genvar i = 0; i < WORD_W; i++) begin : g_stage
        if (i == 0) begin : g_tail
            assign shifted[i] = 1'b0;
        end else begin : g_body
            assign shifted[i] = sreg[i-1];
        end
    end

    // Capture a new word or move one position toward the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= word;
        end else if (advance) begin
            sreg <= shifted;
        end
    end

    // Count the bits already presented in this word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
        end else if (load) begin
            bitcnt <= '0;
        end else if (advance) begin
            bitcnt <= bitcnt + 1'b1;
        end
    end

    assign msb  = sreg[WORD_W-1];
    assign last = (bitcnt == LAST_IDX);

endmodule

// File: rtl/tlw_phase_fsm.sv
// Phase sequencer: idle, then low/high per bit, then gap, strobe and done.
// Assumes: expired comes from a timer this FSM loads on every phase change.
module tlw_phase_fsm
    import tlw_pkg::*;
#(
    parameter int CNT_W      = 2,
    parameter int LOW_CYC    = 3,
    parameter int HIGH_CYC   = 3,
    parameter int GAP_CYC    = 1,
    parameter int STROBE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             expired,
    input  logic             last,
    output phase_t           phase,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sh_load,
    output logic             sh_advance
);

    localparam logic [CNT_W-1:0] LOW_V    = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] HIGH_V   = CNT_W'(HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_V    = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_V = CNT_W'(STROBE_CYC - 1);

    phase_t phase_nxt;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end

    // Next phase, timer reload and shifter controls.
    always_comb begin
        phase_nxt  = phase;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sh_load    = 1'b0;
        sh_advance = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    phase_nxt = PH_LOW;
                    tmr_load  = 1'b1;
                    tmr_val   = LOW_V;
                    sh_load   = 1'b1;
                end
            end
            PH_LOW: begin
                if (expired) begin
                    phase_nxt = PH_HIGH;
                    tmr_load  = 1'b1;
                    tmr_val   = HIGH_V;
                end
            end
            PH_HIGH: begin
                if (expired) begin
                    tmr_load = 1'b1;
                    if (last) begin
                        phase_nxt = PH_GAP;
                        tmr_val   = GAP_V;
                    end else begin
                        phase_nxt  = PH_LOW;
                        tmr_val    = LOW_V;
                        sh_advance = 1'b1;
                    end
                end
            end
            PH_GAP: begin
                if (expired) begin
                    phase_nxt = PH_STROBE;
                    tmr_load  = 1'b1;
                    tmr_val   = STROBE_V;
                end
            end
            PH_STROBE: begin
                if (expired) begin
                    phase_nxt = PH_DONE;
                end
            end
            PH_DONE: begin
                phase_nxt = PH_IDLE;
            end
            default: begin
                phase_nxt = PH_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/three_wire_loader.sv
// Top of the three-wire serial register loader.
// Sends a WORD_W-bit word MSB first and then pulses the latch strobe.
// Assumes: the minimum times in picoseconds and the clock period are set
// for the target clock; every interval is rounded up to whole cycles.
module three_wire_loader
    import tlw_pkg::*;
#(
    parameter int WORD_W        = 21,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int SETUP_PS      = 10000,
    parameter int HOLD_PS       = 10000,
    parameter int HIGH_PS       = 25000,
    parameter int LOW_PS        = 25000,
    parameter int CLK2STB_PS    = 10000,
    parameter int STROBE_PS     = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    output logic              wr_ready,
    output logic              done,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_strobe
);

    localparam int LOW_CYC    = max2(cycles_for(LOW_PS, CLK_PERIOD_PS),
                                     cycles_for(SETUP_PS, CLK_PERIOD_PS));
    localparam int HIGH_CYC   = max2(cycles_for(HIGH_PS, CLK_PERIOD_PS),
                                     cycles_for(HOLD_PS, CLK_PERIOD_PS));
    localparam int GAP_CYC    = cycles_for(CLK2STB_PS, CLK_PERIOD_PS);
    localparam int STROBE_CYC = cycles_for(STROBE_PS, CLK_PERIOD_PS);
    localparam int LONGEST    = max2(max2(LOW_CYC, HIGH_CYC), max2(GAP_CYC, STROBE_CYC));
    localparam int CNT_W      = $clog2(LONGEST + 1);
    localparam int BIT_W      = $clog2(WORD_W);

    phase_t           phase;
    logic             start;
    logic             expired;
    logic             last;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load;
    logic             sh_advance;
    logic             msb;

    assign start = wr_valid & phase[IX_IDLE];

    tlw_phase_fsm #(
        .CNT_W      (CNT_W),
        .LOW_CYC    (LOW_CYC),
        .HIGH_CYC   (HIGH_CYC),
        .GAP_CYC    (GAP_CYC),
        .STROBE_CYC (STROBE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .expired    (expired),
        .last       (last),
        .phase      (phase),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .sh_load    (sh_load),
        .sh_advance (sh_advance)
    );

    tlw_interval_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    tlw_word_shifter #(
        .WORD_W (WORD_W),
        .BIT_W  (BIT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .word    (wr_word),
        .advance (sh_advance),
        .msb     (msb),
        .last    (last)
    );

    // Each pin or handshake bit is a single flop of the one-hot phase or shifter.
    assign wr_ready   = phase[IX_IDLE];
    assign done       = phase[IX_DONE];
    assign ser_clk    = phase[IX_HIGH];
    assign ser_strobe = phase[IX_STROBE];
    assign ser_data   = msb;

endmodule

// File: rtl/tlw_checker.sv
// Protocol checker for the three-wire loader, attached by bind.
// Assumes: the interval lengths are passed in from the loader's localparams.
module tlw_checker #(
    parameter int WORD_W     = 21,
    parameter int LOW_CYC    = 3,
    parameter int HIGH_CYC   = 3,
    parameter int GAP_CYC    = 1,
    parameter int STROBE_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic wr_ready,
    input logic done,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_strobe
);

    localparam logic [15:0] LOW_V  = 16'(LOW_CYC);
    localparam logic [15:0] HIGH_V = 16'(HIGH_CYC);
    localparam logic [15:0] GAP_V  = 16'(GAP_CYC);
    localparam logic [15:0] STB_V  = 16'(STROBE_CYC);
    localparam logic [15:0] WORD_V = 16'(WORD_W);

    logic        clk_q;
    logic        stb_q;
    logic        in_reset_q;
    logic [15:0] hi_len;
    logic [15:0] lo_len;
    logic [15:0] stb_len;
    logic [15:0] pulses;

    // Track previous pin levels and the running length of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q   <= 1'b0;
            stb_q   <= 1'b0;
            hi_len  <= '0;
            lo_len  <= '0;
            stb_len <= '0;
            pulses  <= '0;
        end else begin
            clk_q   <= ser_clk;
            stb_q   <= ser_strobe;
            hi_len  <= ser_clk ? hi_len + 16'd1 : 16'd0;
            lo_len  <= ser_clk ? 16'd0 : lo_len + 16'd1;
            stb_len <= ser_strobe ? stb_len + 16'd1 : 16'd0;
            if (done) begin
                pulses <= '0;
            end else if (ser_clk && !clk_q) begin
                pulses <= pulses + 16'd1;
            end
        end
    end

    // Remember whether reset was applied on the previous edge.
    always_ff @(posedge clk) begin
        in_reset_q <= !rst_n;
    end

    // R1 / R9: outputs idle right after any reset edge.
    always @(posedge clk) begin
        if (in_reset_q) begin
            p_reset_idle_r9: assert (!ser_clk && !ser_strobe && wr_ready && !done)
                else $error("outputs not idle after reset");
        end
    end

    p_accept_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

    p_ready_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> wr_ready);

    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && !done) |=> !wr_ready);

    p_data_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_data));

    p_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_clk && clk_q) |-> (hi_len == HIGH_V));

    p_low_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !clk_q && pulses != 16'd0) |-> (lo_len == LOW_V));

    p_strobe_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_strobe && !stb_q) |-> (lo_len == GAP_V));

    p_pulse_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_strobe && !stb_q) |-> (pulses == WORD_V));

    p_strobe_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_strobe |-> !ser_clk);

    p_strobe_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_strobe && stb_q) |-> (stb_len == STB_V));

    p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ser_strobe && stb_q));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind three_wire_loader tlw_checker #(
    .WORD_W     (WORD_W),
    .LOW_CYC    (LOW_CYC),
    .HIGH_CYC   (HIGH_CYC),
    .GAP_CYC    (GAP_CYC),
    .STROBE_CYC (STROBE_CYC)
) u_tlw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .done       (done),
    .ser_data   (ser_data),
    .ser_clk    (ser_clk),
    .ser_strobe (ser_strobe)
);

// File: tb/three_wire_loader_test.sv
// Bench for the three-wire loader: a vector table, then directed tests.
module three_wire_loader_test;

    localparam int W        = 21;
    localparam int EXP_LOW  = 3;
    localparam int EXP_HIGH = 3;
    localparam int EXP_GAP  = 1;
    localparam int EXP_STB  = 2;
    localparam int EXP_SPAN = W * (EXP_LOW + EXP_HIGH) + EXP_GAP + EXP_STB;

    typedef struct packed {
        logic [W-1:0] word;
        logic [1:0]   sel;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{word: 21'h1FFFFF, sel: 2'd3},
        '{word: 21'h000000, sel: 2'd0},
        '{word: 21'h155555, sel: 2'd1},
        '{word: 21'h0AAAAA, sel: 2'd2},
        '{word: 21'h123456, sel: 2'd2},
        '{word: 21'h1C0001, sel: 2'd1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [W-1:0] wr_word = '0;
    logic         wr_ready, done, ser_data, ser_clk, ser_strobe;

    int checks = 0;
    int failures = 0;

    always #5ns clk = ~clk;

    three_wire_loader uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_word    (wr_word),
        .wr_ready   (wr_ready),
        .done       (done),
        .ser_data   (ser_data),
        .ser_clk    (ser_clk),
        .ser_strobe (ser_strobe)
    );

    // Pin monitor, sampled on the falling clock edge.
    logic         p_clk = 1'b0, p_stb = 1'b0, p_data = 1'b0;
    logic [W-1:0] cap_word = '0;
    int cap_bits = 0, hi_run = 0, lo_run = 0, stb_run = 0;
    int hi_bad = 0, lo_bad = 0, d_bad = 0, gap_seen = -1, stb_len = -1;
    int strobes = 0, done_cnt = 0, done_bad = 0;

    always @(negedge clk) begin
        if (ser_clk && !p_clk) begin
            if (cap_bits > 0 && lo_run != EXP_LOW) lo_bad++;
            if (ser_data != p_data) d_bad++;
            cap_word = {cap_word[W-2:0], ser_data};
            cap_bits++;
        end
        if (ser_clk && p_clk && ser_data != p_data) d_bad++;
        if (!ser_clk && p_clk && hi_run != EXP_HIGH) hi_bad++;
        if (ser_strobe && !p_stb) begin
            gap_seen = lo_run;
            strobes++;
        end
        if (!ser_strobe && p_stb) stb_len = stb_run;
        if (done) begin
            done_cnt++;
            if (!(!ser_strobe && p_stb)) done_bad++;
        end
        hi_run  = ser_clk ? hi_run + 1 : 0;
        lo_run  = ser_clk ? 0 : lo_run + 1;
        stb_run = ser_strobe ? stb_run + 1 : 0;
        p_clk   = ser_clk;
        p_stb   = ser_strobe;
        p_data  = ser_data;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        cap_word = '0; cap_bits = 0; hi_bad = 0; lo_bad = 0; d_bad = 0;
        gap_seen = -1; stb_len = -1; strobes = 0; done_cnt = 0; done_bad = 0;
    endtask

    // Wait for done at falling edges; returns the number of waits.
    task automatic wait_done(output int n, output int rdy_bad);
        n = 0;
        rdy_bad = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
            if (!done && wr_ready) rdy_bad++;
        end
    endtask

    // Send one word and check every pin property of the transfer.
    task automatic run_word(input logic [W-1:0] w, input logic [1:0] sel);
        int n, rb;
        @(negedge clk);
        check_eq("R2", "ready while idle", int'(wr_ready), 1);
        clear_mon();
        wr_valid = 1'b1;
        wr_word  = w;
        @(negedge clk);
        wr_valid = 1'b0;
        check_eq("R2", "ready dropped after accept", int'(wr_ready), 0);
        wait_done(n, rb);
        check_eq("R11", "cycles to done", n, EXP_SPAN);
        check_eq("R2", "ready high while busy", rb, 0);
        @(negedge clk);
        check_eq("R2", "ready back after done", int'(wr_ready), 1);
        check_eq("R8", "done single cycle", int'(done), 0);
        check_eq("R3", "captured word", int'(cap_word), int'(w));
        check_eq("R3", "clock pulse count", cap_bits, W);
        check_eq("R3", "select bits last", int'(cap_word[1:0]), int'(sel));
        check_eq("R4", "data moved while clock high", d_bad, 0);
        check_eq("R5", "high phase length errors", hi_bad, 0);
        check_eq("R5", "low phase length errors", lo_bad, 0);
        check_eq("R6", "clock to strobe gap", gap_seen, EXP_GAP);
        check_eq("R7", "strobe width", stb_len, EXP_STB);
        check_eq("R7", "strobe count", strobes, 1);
        check_eq("R8", "done count", done_cnt, 1);
        check_eq("R8", "done not on strobe fall", done_bad, 0);
    endtask

    initial begin
        int n, rb, seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1", "clk in reset", int'(ser_clk), 0);
        check_eq("R1", "strobe in reset", int'(ser_strobe), 0);
        check_eq("R1", "data in reset", int'(ser_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "ready after reset", int'(wr_ready), 1);
        check_eq("R1", "done after reset", int'(done), 0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            run_word(VECS[i].word, VECS[i].sel);
        end

        // R2: no valid, no activity.
        clear_mon();
        wr_word = 21'h0F0F0F;
        seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (!wr_ready) seen++;
        end
        check_eq("R2", "pulses without valid", cap_bits, 0);
        check_eq("R2", "ready dropped without valid", seen, 0);

        // R10: valid and word change mid-transfer are ignored.
        @(negedge clk);
        clear_mon();
        wr_valid = 1'b1;
        wr_word  = 21'h0C3A5E;
        @(negedge clk);
        wr_word = 21'h1B7F00;
        repeat (60) @(negedge clk);
        wr_valid = 1'b0;
        wait_done(n, rb);
        @(negedge clk);
        check_eq("R10", "word sent despite busy valid", int'(cap_word), 21'h0C3A5E);
        check_eq("R10", "single strobe", strobes, 1);
        clear_mon();
        seen = 0;
        repeat (20) begin
            @(negedge clk);
            if (ser_clk || !wr_ready) seen++;
        end
        check_eq("R10", "no follow-on transfer", seen, 0);

        // R9: reset mid-transfer aborts without a strobe.
        clear_mon();
        wr_valid = 1'b1;
        wr_word  = 21'h1ABCDE;
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_eq("R9", "clk idle after abort", int'(ser_clk), 0);
        check_eq("R9", "data idle after abort", int'(ser_data), 0);
        check_eq("R9", "ready after abort", int'(wr_ready), 1);
        repeat (200) @(negedge clk);
        check_eq("R9", "strobe after abort", strobes, 0);
        check_eq("R9", "done after abort", done_cnt, 0);

        // Recovery after abort.
        run_word(21'h0D2C1B, 2'd3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2ms;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule